// File: doc/BRIEF.md
# Wake-up Filter Register Loader

This block is the register side of a wake-on-LAN controller. It holds the power-management control bits and received-event flags, and it owns a bank of eight 32-bit wake-up filter words. Software reaches the bank through one data address. A 3-bit pointer selects the slot, and the pointer moves on by one after every access. The current pointer value can be read back from the control/status word.

When software writes the data address while the pointer stands at the last slot, the block copies the whole eight-word set into a holding register. It then hands the set to the receive clock domain with a toggle request and a two-flop synchroniser. The receive side latches all eight words at once and raises a one-cycle update strobe. If a new set is committed while the previous transfer is still in flight, the new commit is held back. It is launched as soon as the acknowledge returns, carrying the bank contents at that moment.

Event pulses from the receive domain (magic packet seen, wake-up frame seen) cross back into the bus domain and set sticky flags, which clear when the control/status word is read. The control levels are also synchronised into the receive domain for the frame matcher.

Top module: `wkf_loader`

## Requirements
- R1: After reset, the control/status word (address 0) reads 0x00000000 and `rx_upd` is low.
- R2: A write to the filter address (address 1) stores the word in the slot given by the pointer and then advances the pointer by one, wrapping from 7 to 0. The pointer reads back in bits 26:24 of the control/status word.
- R3: A read of the filter address returns the word in the slot given by the pointer and then advances the pointer by one.
- R4: Writing 1 to bit 31 of the control/status word sets the pointer to 0. Bit 31 reads 1 in the cycle after that write and 0 from the cycle after that on. Writing 0 to bit 31 leaves the pointer unchanged.
- R5: A filter write made while the pointer equals 7 transfers all eight words to `rx_filt`, with slot i in bits [32i+31:32i]. The transfer is marked by `rx_upd` being high for exactly one `rx_clk` cycle.
- R6: A pointer reset issued while a transfer is pending does not cancel that transfer.
- R7: Bit 0 (power-down), bit 1 (magic-packet enable), bit 2 (wake-frame enable) and bit 9 (global unicast enable) are read/write. All other bits except 31, 26:24, 6 and 5 read 0 and ignore writes. Bits 6 and 5 ignore writes.
- R8: A pulse on `rx_magic_hit` sets bit 5 and a pulse on `rx_frame_hit` sets bit 6. Each bit reads 1 until the control/status word is read, and reads 0 on the next read.
- R9: Bits 0, 1, 2 and 9 appear on `rx_pwrdn`, `rx_magic_en`, `rx_frame_en` and `rx_ucast_en` after a two-flop synchronisation in the `rx_clk` domain.
- R10: A filter set committed while an earlier transfer is still unacknowledged is delivered afterwards, as a separate update carrying the newer contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: 0 control/status, 1 filter data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Asynchronous active-low reset, receive domain |
| rx_magic_hit | input | 1 | One-cycle pulse: magic packet received |
| rx_frame_hit | input | 1 | One-cycle pulse: wake-up frame received |
| rx_filt | output | NWORDS*32 | Committed filter set, receive domain |
| rx_upd | output | 1 | One-cycle strobe when `rx_filt` changes |
| rx_pwrdn | output | 1 | Synchronised power-down control |
| rx_magic_en | output | 1 | Synchronised magic-packet enable |
| rx_frame_en | output | 1 | Synchronised wake-frame enable |
| rx_ucast_en | output | 1 | Synchronised global unicast enable |

## Verification
A pointer that drifts shows up at the next control/status read in bits 26:24. It also shows up as a wrong word on the next filter read, and as a shifted set in the next `rx_filt` update, a few receive cycles after the commit. A broken request/acknowledge pair shows up as a missing, duplicated or stale update: the scoreboard expects exactly one delivery per commit, in commit order. Sticky flags that fail to set or clear show up on the first or second status read after the event pulse.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NWORDS  = 8;
  localparam int unsigned PTR_W   = $clog2(NWORDS);

  localparam int unsigned BIT_PWRDN  = 0;
  localparam int unsigned BIT_MGK_EN = 1;
  localparam int unsigned BIT_FRM_EN = 2;
  localparam int unsigned BIT_MGK_RX = 5;
  localparam int unsigned BIT_FRM_RX = 6;
  localparam int unsigned BIT_UCAST  = 9;
  localparam int unsigned PTR_LSB    = 24;
  localparam int unsigned BIT_PCLR   = 31;

  typedef struct packed {
    logic pwrdn;
    logic mgk_en;
    logic frm_en;
    logic ucast_en;
  } wkf_ctrl_t;
endpackage

// File: rtl/wkf_bit_sync.sv
module wkf_bit_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/wkf_pulse_xfer.sv
module wkf_pulse_xfer (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic tog_q, tog_d;
  logic tog_s;
  logic seen_q;

  always_comb tog_d = tog_q ^ src_pulse;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  wkf_bit_sync #(.W(1)) u_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(tog_q), .q(tog_s)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) seen_q <= 1'b0;
    else            seen_q <= tog_s;
  end

  assign dst_pulse = tog_s ^ seen_q;
endmodule

// File: rtl/wkf_filt_bank.sv
module wkf_filt_bank
  import wkf_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned NW = NWORDS,
  localparam int unsigned PW = $clog2(NW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [DW-1:0]  wdata,
  input  logic           ptr_clr,
  input  logic           ack_tog,
  output logic [PW-1:0]  ptr,
  output logic [DW-1:0]  rd_word,
  output logic [NW*DW-1:0] hold,
  output logic           req_tog
);
  logic [DW-1:0]    mem_q [NW];
  logic [DW-1:0]    mem_d [NW];
  logic [PW-1:0]    ptr_q, ptr_d;
  logic [NW*DW-1:0] hold_q, hold_d;
  logic             req_q, req_d;
  logic             defer_q, defer_d;
  logic             busy, commit, launch;

  always_comb begin
    busy   = req_q ^ ack_tog;
    commit = wr_en && (ptr_q == PW'(NW - 1));
    launch = (commit || defer_q) && !busy;

    for (int i = 0; i < NW; i++) mem_d[i] = mem_q[i];
    if (wr_en) mem_d[ptr_q] = wdata;

    if (ptr_clr)             ptr_d = '0;
    else if (wr_en || rd_en) ptr_d = ptr_q + 1'b1;
    else                     ptr_d = ptr_q;

    hold_d = hold_q;
    if (launch)
      for (int i = 0; i < NW; i++) hold_d[i*DW +: DW] = mem_d[i];

    req_d = launch ? ~req_q : req_q;

    if (launch)              defer_d = 1'b0;
    else if (commit && busy) defer_d = 1'b1;
    else                     defer_d = defer_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem_q[i] <= '0;
      ptr_q   <= '0;
      hold_q  <= '0;
      req_q   <= 1'b0;
      defer_q <= 1'b0;
    end else begin
      if (wr_en) mem_q[ptr_q] <= mem_d[ptr_q];
      ptr_q   <= ptr_d;
      if (launch) hold_q <= hold_d;
      req_q   <= req_d;
      defer_q <= defer_d;
    end
  end

  assign ptr     = ptr_q;
  assign rd_word = mem_q[ptr_q];
  assign hold    = hold_q;
  assign req_tog = req_q;

  AST_PTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && !ptr_clr |=> ptr_q == PW'($past(ptr_q) + 1'b1)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(hold_q)); // R5
endmodule

// File: rtl/wkf_rx_capture.sv
module wkf_rx_capture
  import wkf_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned NW = NWORDS
) (
  input  logic             rx_clk,
  input  logic             rx_rst_n,
  input  logic             req_tog,
  input  logic [NW*DW-1:0] hold,
  output logic [NW*DW-1:0] filt,
  output logic             upd,
  output logic             ack_tog
);
  logic             req_s;
  logic             seen_q, seen_d;
  logic [NW*DW-1:0] filt_q, filt_d;
  logic             upd_q, upd_d;
  logic             edge_det;

  wkf_bit_sync #(.W(1)) u_req_sync (
    .clk(rx_clk), .rst_n(rx_rst_n), .d(req_tog), .q(req_s)
  );

  always_comb begin
    edge_det = req_s ^ seen_q;
    seen_d   = req_s;
    upd_d    = edge_det;
    filt_d   = edge_det ? hold : filt_q;
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      seen_q <= 1'b0;
      upd_q  <= 1'b0;
      filt_q <= '0;
    end else begin
      seen_q <= seen_d;
      upd_q  <= upd_d;
      if (edge_det) filt_q <= filt_d;
    end
  end

  assign filt    = filt_q;
  assign upd     = upd_q;
  assign ack_tog = seen_q;

  AST_UPD_ONE: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    upd_q |=> !upd_q); // R5
endmodule

// File: rtl/wkf_loader.sv
module wkf_loader
  import wkf_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned NW     = NWORDS,
  localparam int unsigned DW    = WORD_W,
  localparam int unsigned PW    = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             rx_clk,
  input  logic             rx_rst_n,
  input  logic             rx_magic_hit,
  input  logic             rx_frame_hit,
  output logic [NW*DW-1:0] rx_filt,
  output logic             rx_upd,
  output logic             rx_pwrdn,
  output logic             rx_magic_en,
  output logic             rx_frame_en,
  output logic             rx_ucast_en
);
  localparam logic [ADDR_W-1:0] A_CSR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(1);

  logic wr_csr, rd_csr, wr_filt, rd_filt;
  logic ptr_clr;
  wkf_ctrl_t ctrl_q, ctrl_d;
  logic pclr_q, pclr_d;
  logic mgk_rx_q, mgk_rx_d, frm_rx_q, frm_rx_d;
  logic mgk_set, frm_set;
  logic [PW-1:0]    ptr;
  logic [DW-1:0]    rd_word;
  logic [NW*DW-1:0] hold;
  logic             req_tog, ack_tog_rx, ack_tog;
  logic [3:0]       ctrl_rx;

  always_comb begin
    wr_csr  = bus_sel &&  bus_wr && (bus_addr == A_CSR);
    rd_csr  = bus_sel && !bus_wr && (bus_addr == A_CSR);
    wr_filt = bus_sel &&  bus_wr && (bus_addr == A_FILT);
    rd_filt = bus_sel && !bus_wr && (bus_addr == A_FILT);
    ptr_clr = wr_csr && bus_wdata[BIT_PCLR];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_csr) begin
      ctrl_d.pwrdn    = bus_wdata[BIT_PWRDN];
      ctrl_d.mgk_en   = bus_wdata[BIT_MGK_EN];
      ctrl_d.frm_en   = bus_wdata[BIT_FRM_EN];
      ctrl_d.ucast_en = bus_wdata[BIT_UCAST];
    end
    pclr_d   = ptr_clr;
    mgk_rx_d = mgk_set ? 1'b1 : (rd_csr ? 1'b0 : mgk_rx_q);
    frm_rx_d = frm_set ? 1'b1 : (rd_csr ? 1'b0 : frm_rx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pclr_q   <= 1'b0;
      mgk_rx_q <= 1'b0;
      frm_rx_q <= 1'b0;
    end else begin
      if (wr_csr) ctrl_q <= ctrl_d;
      pclr_q   <= pclr_d;
      mgk_rx_q <= mgk_rx_d;
      frm_rx_q <= frm_rx_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_csr) begin
      bus_rdata[BIT_PWRDN]  = ctrl_q.pwrdn;
      bus_rdata[BIT_MGK_EN] = ctrl_q.mgk_en;
      bus_rdata[BIT_FRM_EN] = ctrl_q.frm_en;
      bus_rdata[BIT_UCAST]  = ctrl_q.ucast_en;
      bus_rdata[BIT_MGK_RX] = mgk_rx_q;
      bus_rdata[BIT_FRM_RX] = frm_rx_q;
      bus_rdata[PTR_LSB +: PW] = ptr;
      bus_rdata[BIT_PCLR]   = pclr_q;
    end else if (rd_filt) begin
      bus_rdata = rd_word;
    end
  end

  wkf_filt_bank #(.DW(DW), .NW(NW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_filt), .rd_en(rd_filt),
    .wdata(bus_wdata), .ptr_clr(ptr_clr), .ack_tog(ack_tog),
    .ptr(ptr), .rd_word(rd_word), .hold(hold), .req_tog(req_tog)
  );

  wkf_rx_capture #(.DW(DW), .NW(NW)) u_rx (
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .req_tog(req_tog), .hold(hold),
    .filt(rx_filt), .upd(rx_upd), .ack_tog(ack_tog_rx)
  );

  wkf_bit_sync #(.W(1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tog_rx), .q(ack_tog)
  );

  wkf_pulse_xfer u_mgk_xfer (
    .src_clk(rx_clk), .src_rst_n(rx_rst_n), .src_pulse(rx_magic_hit),
    .dst_clk(clk), .dst_rst_n(rst_n), .dst_pulse(mgk_set)
  );

  wkf_pulse_xfer u_frm_xfer (
    .src_clk(rx_clk), .src_rst_n(rx_rst_n), .src_pulse(rx_frame_hit),
    .dst_clk(clk), .dst_rst_n(rst_n), .dst_pulse(frm_set)
  );

  wkf_bit_sync #(.W(4)) u_ctrl_sync (
    .clk(rx_clk), .rst_n(rx_rst_n), .d(ctrl_q), .q(ctrl_rx)
  );

  assign rx_pwrdn    = ctrl_rx[3];
  assign rx_magic_en = ctrl_rx[2];
  assign rx_frame_en = ctrl_rx[1];
  assign rx_ucast_en = ctrl_rx[0];

  AST_PTRRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pclr_q |-> ptr == '0); // R4
  AST_MGK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_csr && !mgk_set |=> !mgk_rx_q); // R8
  AST_FRM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_csr && !frm_set |=> !frm_rx_q); // R8
endmodule

// File: tb/wkf_loader_bench.sv
module wkf_loader_bench;
  localparam int CLK_NS = 10;
  localparam int RX_NS  = 37;
  localparam int NW     = 8;

  logic clk = 1'b0, rx_clk = 1'b0;
  logic rst_n = 1'b0, rx_rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rx_magic_hit = 1'b0, rx_frame_hit = 1'b0;
  logic [NW*32-1:0] rx_filt;
  logic rx_upd, rx_pwrdn, rx_magic_en, rx_frame_en, rx_ucast_en;

  int checks = 0, errors = 0, deliveries = 0;
  logic [NW*32-1:0] exp_q[$];
  logic done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always #(RX_NS/2)  rx_clk = ~rx_clk;

  wkf_loader u_wkf_loader (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_magic_hit(rx_magic_hit),
    .rx_frame_hit(rx_frame_hit), .rx_filt(rx_filt), .rx_upd(rx_upd),
    .rx_pwrdn(rx_pwrdn), .rx_magic_en(rx_magic_en),
    .rx_frame_en(rx_frame_en), .rx_ucast_en(rx_ucast_en)
  );

  function automatic logic [31:0] wgen(input int set, input int i);
    return {8'(set), 8'hA5, 8'(i), 8'(set * 7 + i * 13)};
  endfunction

  function automatic logic [NW*32-1:0] sgen(input int set);
    logic [NW*32-1:0] v;
    for (int i = 0; i < NW; i++) v[i*32 +: 32] = wgen(set, i);
    return v;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 check(req, 256'(bus_rdata), 256'(exp));
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_set(input int set);
    for (int i = 0; i < NW; i++) bus_write(2'd1, wgen(set, i));
    exp_q.push_back(sgen(set));
  endtask

  // monitor: pops expected filter sets as updates appear in the rx domain
  logic prev_upd = 1'b0;
  always @(negedge rx_clk) begin
    if (rx_upd) begin
      deliveries++;
      check("R5 strobe one cycle", 256'(prev_upd), 256'(0));
      if (exp_q.size() == 0) begin
        check("R5 unexpected update", 256'(1), 256'(0));
      end else begin
        logic [NW*32-1:0] e;
        e = exp_q.pop_front();
        check("R5 R10 filter set", rx_filt, e);
      end
    end
    prev_upd = rx_upd;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1; rx_rst_n = 1'b1;
    idle(2);
    // R1 reset state
    bus_read("R1 csr reset", 2'd0, 32'h0);
    check("R1 upd reset", 256'(rx_upd), 256'(0));
    // R7 reserved and status bits ignore writes
    bus_write(2'd0, 32'h7FFF_FFFF);
    bus_read("R7 rw bits", 2'd0, 32'h0000_0207);
    // R9 control levels reach rx domain
    idle(12);
    check("R9 rx controls", 256'({rx_pwrdn, rx_magic_en, rx_frame_en, rx_ucast_en}), 256'(4'hF));
    bus_write(2'd0, 32'h0);
    bus_read("R7 clear", 2'd0, 32'h0);
    // R2 pointer advance on writes
    bus_write(2'd1, 32'h1111_0000);
    bus_write(2'd1, 32'h2222_0000);
    bus_write(2'd1, 32'h3333_0000);
    bus_read("R2 ptr after 3", 2'd0, 32'h0300_0000);
    // R4 pointer reset self-clears
    bus_write(2'd0, 32'h8000_0000);
    bus_read("R4 bit31 set", 2'd0, 32'h8000_0000);
    bus_read("R4 bit31 clr", 2'd0, 32'h0);
    bus_write(2'd1, 32'h4444_0000);
    bus_write(2'd1, 32'h5555_0000);
    bus_write(2'd0, 32'h0);
    bus_read("R4 zero no effect", 2'd0, 32'h0200_0000);
    bus_write(2'd0, 32'h8000_0000);
    // R5 full set commit
    load_set(1);
    bus_read("R2 wrap", 2'd0, 32'h0);
    // R3 reads return slot and advance
    bus_read("R3 read slot0", 2'd1, wgen(1, 0));
    bus_read("R3 ptr after read", 2'd0, 32'h0100_0000);
    for (int i = 1; i < NW; i++) bus_read("R3 read slot", 2'd1, wgen(1, i));
    bus_read("R3 ptr wrap", 2'd0, 32'h0);
    idle(40);
    check("R5 one delivery", 256'(deliveries), 256'(1));
    // R10 commit while busy is deferred
    load_set(2);
    load_set(3);
    idle(80);
    check("R10 deliveries", 256'(deliveries), 256'(3));
    // R6 pointer reset while pending
    load_set(4);
    bus_write(2'd0, 32'h8000_0000);
    bus_read("R6 ptr reset", 2'd0, 32'h8000_0000);
    idle(60);
    check("R6 delivered", 256'(deliveries), 256'(4));
    // R8 status flags
    @(negedge rx_clk); rx_magic_hit = 1'b1;
    @(negedge rx_clk); rx_magic_hit = 1'b0;
    idle(10);
    bus_read("R8 magic set", 2'd0, 32'h0000_0020);
    bus_read("R8 magic clr", 2'd0, 32'h0);
    @(negedge rx_clk); rx_frame_hit = 1'b1;
    @(negedge rx_clk); rx_frame_hit = 1'b0;
    idle(10);
    bus_read("R8 frame set", 2'd0, 32'h0000_0040);
    bus_read("R8 frame clr", 2'd0, 32'h0);
    check("R5 queue drained", 256'(exp_q.size()), 256'(0));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule